// File: doc/BRIEF.md
# Timer channel output control

This block is the per-channel output stage that turns timer events into waveform pins. Each channel keeps four bits of state: an output state bit, an enable bit, a polarity bit and a mode bit. In toggle mode, every channel event flips the pin. In PWM mode, a period event drives the pin to its active level and a duty event drives it back to its inactive level. The polarity bit selects which pin level counts as active.

Software writes through one register port. Each write carries a register select and a per-channel mask, so it can change any subset of channels without touching the others, including channels that are running. Software sets the starting pin level by writing the output state while a channel is disabled. When the enable bit is then set, the waveform begins from that level. The counter, the interrupt logic and the pin multiplexing sit outside this block.

Top module: `tmr_out_ctrl`

## Requirements
- R1: After reset, every output state, enable, polarity and mode bit is 0, and every pin_o bit is 0.
- R2: A write (wr_valid_i=1) changes only the channels whose wr_mask_i bit is 1. The register select codes are: 0 = output state, 1 = enable, 2 = polarity, 3 = mode. Each channel takes its value from its own wr_data_i bit.
- R3: A write to the output state (code 0) takes effect only on channels whose enable is 0. On enabled channels it is ignored.
- R4: While a channel's enable is 0, neither chan_evt_i nor per_evt_i changes its output state or its pin.
- R5: With mode 0 (toggle) and enable 1, a chan_evt_i pulse inverts the pin. per_evt_i has no effect, and the pin equals the output state whatever the polarity bit holds.
- R6: With mode 1 (PWM) and enable 1, a per_evt_i pulse sets the output state to 1. A chan_evt_i pulse clears it to 0. The pin is the output state XOR the polarity bit: polarity 0 means active high, polarity 1 means active low.
- R7: In PWM mode, if chan_evt_i and per_evt_i arrive on one channel in the same cycle, the output state becomes 0 (inactive).
- R8: Setting the enable bit does not change the pin. The pin holds the preloaded level until the first event after enable.
- R9: A polarity write on a running PWM channel flips its pin in the next cycle and leaves its output state unchanged.
- R10: All register and state changes appear on pin_o one clock edge after the input cycle that causes them. Events use the register values in effect before a same-cycle write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Register write strobe |
| wr_reg_i | input | 2 | Register select: 0 state, 1 enable, 2 polarity, 3 mode |
| wr_mask_i | input | NUM_CH | Channels affected by the write |
| wr_data_i | input | NUM_CH | Per-channel write value |
| chan_evt_i | input | NUM_CH | Channel event: toggles in mode 0, clears in mode 1 |
| per_evt_i | input | NUM_CH | Period event: sets in mode 1 |
| pin_o | output | NUM_CH | Waveform pins |

## Verification
The hardest situations to reach are the ones where several things happen in one cycle: a write and an event on the same channel, or both events together. Here the order of precedence decides the result. The bench reaches them with a pseudo-random sweep. It drives every register select, mask, data and event pattern in the same cycle across all eight channels, and compares each cycle against a bench-side model. A directed sequence first walks one set of channels through preload, enable, toggle, the switch to PWM, a polarity change and simultaneous events, so that each rule is checked against a known constant.

// File: rtl/tmr_out_pkg.sv
package tmr_out_pkg;
  typedef enum logic [1:0] {
    REG_STATE = 2'd0,
    REG_EN    = 2'd1,
    REG_POL   = 2'd2,
    REG_MODE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_out_wdec.sv
module tmr_out_wdec #(
  parameter int NUM_CH = 8
) (
  input  logic              wr_valid_i,
  input  logic [1:0]        wr_reg_i,
  input  logic [NUM_CH-1:0] wr_mask_i,
  output logic [NUM_CH-1:0] st_we_o,
  output logic [NUM_CH-1:0] en_we_o,
  output logic [NUM_CH-1:0] pol_we_o,
  output logic [NUM_CH-1:0] mode_we_o
);
  import tmr_out_pkg::*;

  logic [NUM_CH-1:0] gated;
  assign gated = wr_valid_i ? wr_mask_i : '0;

  always_comb begin
    st_we_o   = '0;
    en_we_o   = '0;
    pol_we_o  = '0;
    mode_we_o = '0;
    unique case (reg_sel_e'(wr_reg_i))
      REG_STATE: st_we_o   = gated;
      REG_EN:    en_we_o   = gated;
      REG_POL:   pol_we_o  = gated;
      REG_MODE:  mode_we_o = gated;
      default:   ;
    endcase
  end
endmodule

// File: rtl/tmr_out_chan.sv
module tmr_out_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic st_we_i,
  input  logic en_we_i,
  input  logic pol_we_i,
  input  logic mode_we_i,
  input  logic wdata_i,
  input  logic chan_evt_i,
  input  logic per_evt_i,
  output logic st_o,
  output logic en_o,
  output logic pol_o,
  output logic mode_o,
  output logic pin_o
);
  logic st_q, en_q, pol_q, mode_q, st_nxt;

  // events act on pre-write register values
  always_comb begin
    st_nxt = st_q;
    if (!en_q) begin
      if (st_we_i) st_nxt = wdata_i;
    end else if (mode_q) begin
      if (chan_evt_i)     st_nxt = 1'b0;  // clear wins over set
      else if (per_evt_i) st_nxt = 1'b1;
    end else if (chan_evt_i) begin
      st_nxt = ~st_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= 1'b0;
      en_q   <= 1'b0;
      pol_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      st_q <= st_nxt;
      if (en_we_i)   en_q   <= wdata_i;
      if (pol_we_i)  pol_q  <= wdata_i;
      if (mode_we_i) mode_q <= wdata_i;
    end
  end

  assign pin_o  = st_q ^ (mode_q & pol_q);
  assign st_o   = st_q;
  assign en_o   = en_q;
  assign pol_o  = pol_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/tmr_out_ctrl.sv
module tmr_out_ctrl #(
  parameter int NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [1:0]        wr_reg_i,
  input  logic [NUM_CH-1:0] wr_mask_i,
  input  logic [NUM_CH-1:0] wr_data_i,
  input  logic [NUM_CH-1:0] chan_evt_i,
  input  logic [NUM_CH-1:0] per_evt_i,
  output logic [NUM_CH-1:0] pin_o
);
  logic [NUM_CH-1:0] st_we, en_we, pol_we, mode_we;
  logic [NUM_CH-1:0] st_q, en_q, pol_q, mode_q;

  tmr_out_wdec #(.NUM_CH(NUM_CH)) u_wdec (
    .wr_valid_i (wr_valid_i),
    .wr_reg_i   (wr_reg_i),
    .wr_mask_i  (wr_mask_i),
    .st_we_o    (st_we),
    .en_we_o    (en_we),
    .pol_we_o   (pol_we),
    .mode_we_o  (mode_we)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    tmr_out_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .st_we_i    (st_we[i]),
      .en_we_i    (en_we[i]),
      .pol_we_i   (pol_we[i]),
      .mode_we_i  (mode_we[i]),
      .wdata_i    (wr_data_i[i]),
      .chan_evt_i (chan_evt_i[i]),
      .per_evt_i  (per_evt_i[i]),
      .st_o       (st_q[i]),
      .en_o       (en_q[i]),
      .pol_o      (pol_q[i]),
      .mode_o     (mode_q[i]),
      .pin_o      (pin_o[i])
    );
  end
endmodule

// File: rtl/tmr_out_ctrl_chk.sv
module tmr_out_ctrl_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic [1:0]        wr_reg_i,
  input logic [NUM_CH-1:0] wr_mask_i,
  input logic [NUM_CH-1:0] chan_evt_i,
  input logic [NUM_CH-1:0] per_evt_i,
  input logic [NUM_CH-1:0] st_q,
  input logic [NUM_CH-1:0] en_q,
  input logic [NUM_CH-1:0] pol_q,
  input logic [NUM_CH-1:0] mode_q
);
  logic st_wr;
  assign st_wr = wr_valid_i && (wr_reg_i == 2'd0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ast
    AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_valid_i && wr_mask_i[i]) |=> ($stable(en_q[i]) && $stable(pol_q[i]) && $stable(mode_q[i]))); // R2
    AST_STATE_WR_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_q[i] && st_wr && wr_mask_i[i] && !chan_evt_i[i] && !per_evt_i[i]) |=> $stable(st_q[i])); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_q[i] && !(st_wr && wr_mask_i[i])) |=> $stable(st_q[i])); // R4
    AST_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_q[i] && !mode_q[i] && chan_evt_i[i]) |=> (st_q[i] != $past(st_q[i]))); // R5
    AST_PWM_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_q[i] && mode_q[i] && per_evt_i[i] && !chan_evt_i[i]) |=> st_q[i]); // R6
    AST_PWM_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_q[i] && mode_q[i] && chan_evt_i[i]) |=> !st_q[i]); // R7
  end
endmodule

bind tmr_out_ctrl tmr_out_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_valid_i (wr_valid_i),
  .wr_reg_i   (wr_reg_i),
  .wr_mask_i  (wr_mask_i),
  .chan_evt_i (chan_evt_i),
  .per_evt_i  (per_evt_i),
  .st_q       (st_q),
  .en_q       (en_q),
  .pol_q      (pol_q),
  .mode_q     (mode_q)
);

// File: tb/sim_tmr_out_ctrl.sv
module sim_tmr_out_ctrl;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [1:0] wr_reg = '0;
  logic [N-1:0] wr_mask = '0, wr_data = '0, cevt = '0, pevt = '0;
  logic [N-1:0] pin;

  logic [N-1:0] m_st = '0, m_en = '0, m_pol = '0, m_mode = '0;
  int n_chk = 0, n_err = 0;
  logic [31:0] lfsr = 32'h1ACE_5EED;

  always #4 clk = ~clk;  // 125 MHz

  tmr_out_ctrl #(.NUM_CH(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_reg_i(wr_reg),
    .wr_mask_i(wr_mask), .wr_data_i(wr_data), .chan_evt_i(cevt),
    .per_evt_i(pevt), .pin_o(pin)
  );

  function automatic logic [N-1:0] m_pin();
    return m_st ^ (m_mode & m_pol);
  endfunction

  // model step from requirements, using pre-write register values
  task automatic model_step();
    logic [N-1:0] nst = m_st;
    for (int i = 0; i < N; i++) begin
      if (!m_en[i]) begin
        if (wr_valid && wr_reg == 2'd0 && wr_mask[i]) nst[i] = wr_data[i];
      end else if (m_mode[i]) begin
        if (cevt[i]) nst[i] = 1'b0;
        else if (pevt[i]) nst[i] = 1'b1;
      end else if (cevt[i]) nst[i] = ~m_st[i];
    end
    for (int i = 0; i < N; i++) begin
      if (wr_valid && wr_mask[i]) begin
        case (wr_reg)
          2'd1: m_en[i]   = wr_data[i];
          2'd2: m_pol[i]  = wr_data[i];
          2'd3: m_mode[i] = wr_data[i];
          default: ;
        endcase
      end
    end
    m_st = nst;
  endtask

  // called at negedge: drive, run one edge, return at next negedge
  task automatic cyc(input logic v, input logic [1:0] r, input logic [N-1:0] m,
                     input logic [N-1:0] d, input logic [N-1:0] ce, input logic [N-1:0] pe);
    wr_valid = v; wr_reg = r; wr_mask = m; wr_data = d; cevt = ce; pevt = pe;
    @(posedge clk);
    model_step();
    @(negedge clk);
    wr_valid = 1'b0; cevt = '0; pevt = '0;
  endtask

  task automatic chk(input string tag, input logic [N-1:0] exp);
    n_chk++;
    if (pin !== exp) begin
      n_err++;
      $display("FAIL %s: pin_o=%h expected %h", tag, pin, exp);
    end
  endtask

  initial begin
    #(8 * 100000);
    n_err++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset pins low", 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", 8'h00);

    cyc(1, 2'd0, 8'hFF, 8'hA5, '0, '0);
    chk("R3 preload while disabled", 8'hA5);
    cyc(0, 2'd0, '0, '0, 8'hFF, 8'hFF);
    chk("R4 events ignored while disabled", 8'hA5);
    cyc(1, 2'd1, 8'h0F, 8'hFF, '0, '0);
    chk("R8 enable keeps preload", 8'hA5);
    chk("R2 enable mask", m_pin());
    cyc(0, 2'd0, '0, '0, 8'hFF, '0);
    chk("R5 toggle enabled only", 8'hAA);
    cyc(1, 2'd0, 8'hFF, 8'h00, '0, '0);
    chk("R3 state write blocked when enabled", 8'h0A);
    cyc(1, 2'd2, 8'hFF, 8'hFF, '0, 8'hFF);
    chk("R5 polarity and period ignored in toggle", 8'h0A);
    cyc(1, 2'd3, 8'hFF, 8'hFF, '0, '0);
    chk("R6 PWM polarity applied", 8'hF5);
    cyc(0, 2'd0, '0, '0, '0, 8'hFF);
    chk("R6 period sets active", 8'hF0);
    cyc(1, 2'd2, 8'h03, 8'h00, '0, '0);
    chk("R9 polarity flip while running", 8'hF3);
    cyc(0, 2'd0, '0, '0, 8'h0F, 8'h0F);
    chk("R7 both events clear", 8'hFC);
    cyc(1, 2'd1, 8'hF0, 8'hF0, '0, '0);
    chk("R8 enable PWM channels no change", 8'hFC);
    cyc(0, 2'd0, '0, '0, 8'h10, 8'h20);
    chk("R6 first events after enable", 8'hDC);
    // R10: event using pre-write mode: ch0 mode1->0 written with clear event
    cyc(1, 2'd3, 8'h01, 8'h00, 8'h01, '0);
    chk("R10 event uses old mode", m_pin());

    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] a, b, c, e;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr[7:0]; b = lfsr[15:8]; c = lfsr[23:16]; e = lfsr[31:24];
      cyc(lfsr[3] | lfsr[9], lfsr[13:12], a, b, c & e, e ^ a);
      chk("R6 sweep vs model", m_pin());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule